// File: doc/BRIEF.md
# Three-Level Control Pin Pulse Qualifier

The block turns one control pin, seen through an outside comparator front end, into single-cycle count-up and count-down strobes for a settings counter. The front end reports the pin level on two flags. One flag means the pin is above the high threshold and the other means it is below the low threshold. With neither flag set, the pin is at its mid-level idle state, which is also where a floating pin rests. An excursion from mid down to low requests a count up. An excursion from mid up to high requests a count down.

An excursion counts only if it lasts longer than `ACCEPT_US` microseconds. The strobe is issued once, when the pin returns to mid. Shorter glitches give nothing. A new excursion is considered only after the pin has been back at mid for `GAP_US` microseconds. After reset, the first excursion that would qualify is swallowed, because the comparators power up in an unknown state. The enable input gates everything: while it is low, no strobe leaves the block and any excursion in progress is dropped. All time is measured in microseconds derived from the clock by `CYC_PER_US`.

Top module: `tri_pulse_qual`

## Requirements
- R1: While `rst_ni` is low, `up_o` and `dn_o` are low, and the next qualifying excursion after reset is marked to be discarded.
- R2: An excursion toward low that is held longer than `ACCEPT_US` µs produces exactly one one-cycle pulse on `up_o`. The pulse comes when the pin returns to mid, three clock edges after the first mid sample at the inputs. This assumes the block is enabled and the first-pulse discard is already used up.
- R3: Under the same conditions, an excursion toward high produces exactly one one-cycle pulse on `dn_o`.
- R4: An excursion held for at most `ACCEPT_US` µs produces no strobe. Length is counted in synchronized cycles, excluding the cycle the excursion is first seen; with `CYC_PER_US`=2 and `ACCEPT_US`=100, 200 cycles are rejected and 201 are accepted. An excursion that jumps directly to the opposite level also produces no strobe.
- R5: The first excursion after reset that would otherwise qualify produces no strobe. It does use up the discard, so the following excursion is counted.
- R6: An excursion that starts before the pin has been at mid for more than `GAP_US` µs since the last excursion (or since reset or enable) is ignored entirely.
- R7: While `en_i` is low, `up_o` and `dn_o` stay low. An excursion in progress when `en_i` falls is cancelled. After `en_i` rises, the mid-level spacing of R6 applies again.
- R8: When both level flags are high at once, the pin is treated as being at mid.
- R9: `up_o` and `dn_o` are never high together. Each pulse lasts one cycle, and no strobe is issued while the pin is still held away from mid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low blocks strobes and cancels a pending excursion |
| lvl_hi_i | input | 1 | Comparator flag: pin above the high threshold (asynchronous) |
| lvl_lo_i | input | 1 | Comparator flag: pin below the low threshold (asynchronous) |
| up_o | output | 1 | One-cycle count-up strobe (excursion was toward low) |
| dn_o | output | 1 | One-cycle count-down strobe (excursion was toward high) |

## Verification
Some properties are checked every cycle: the two strobes are mutually exclusive and last a single cycle, nothing is emitted the cycle after the enable is low or while the discard is pending, and a strobe always follows a mid sample. Other behaviour only the scenarios can show. This covers the exact acceptance boundary at 200 versus 201 cycles, the spacing window after a return to mid, the swallowed first pulse, cancellation when the enable drops mid-excursion, the reversal case, and the conflicting-flag case. For these, a cycle-level behavioural model is compared with both strobes on every clock, and strobe counts are checked per scenario.

// File: rtl/tpq_pkg.sv
package tpq_pkg;
  typedef enum logic [1:0] {LV_MID, LV_HI, LV_LO} lvl_e;
  typedef enum logic [1:0] {ST_GAP, ST_READY, ST_PULSE} st_e;
endpackage

// File: rtl/tpq_sync.sv
module tpq_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/tpq_decode.sv
module tpq_decode
  import tpq_pkg::*;
(
  input  logic hi_i,
  input  logic lo_i,
  output lvl_e lvl_o
);
  // conflicting flags fall back to idle
  always_comb begin
    unique case ({hi_i, lo_i})
      2'b10:   lvl_o = LV_HI;
      2'b01:   lvl_o = LV_LO;
      default: lvl_o = LV_MID;
    endcase
  end
endmodule

// File: rtl/tpq_timer.sv
module tpq_timer #(
  parameter int CYC_PER_US = 100,
  parameter int LIMIT_US   = 100,
  parameter int US_W       = $clog2(LIMIT_US + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            run_i,
  output logic [US_W-1:0] us_o
);
  localparam int PRE_W = $clog2(CYC_PER_US + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);
  localparam logic [US_W-1:0]  US_MAX   = US_W'(LIMIT_US);

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (run_i && us_q != US_MAX) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        us_q  <= us_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign us_o = us_q;
endmodule

// File: rtl/tri_pulse_qual.sv
module tri_pulse_qual
  import tpq_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int ACCEPT_US  = 100,
  parameter int GAP_US     = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_hi_i,
  input  logic lvl_lo_i,
  output logic up_o,
  output logic dn_o
);
  localparam int US_W = $clog2(ACCEPT_US + 1);
  localparam logic [US_W-1:0] ACC_T = US_W'(ACCEPT_US);
  localparam logic [US_W-1:0] GAP_T = US_W'(GAP_US);

  logic [1:0]      flg_s;
  lvl_e            lvl;
  logic            at_mid;
  st_e             st_q, st_d;
  lvl_e            dir_q, dir_d;
  logic            first_q, first_d;
  logic            up_d, dn_d;
  logic            tmr_clr, tmr_run;
  logic [US_W-1:0] us;

  tpq_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lvl_hi_i, lvl_lo_i}),
    .q_o   (flg_s)
  );

  tpq_decode u_dec (
    .hi_i (flg_s[1]),
    .lo_i (flg_s[0]),
    .lvl_o(lvl)
  );

  tpq_timer #(
    .CYC_PER_US(CYC_PER_US),
    .LIMIT_US  (ACCEPT_US),
    .US_W      (US_W)
  ) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .run_i (tmr_run),
    .us_o  (us)
  );

  assign at_mid = (lvl == LV_MID);

  always_comb begin
    st_d    = st_q;
    dir_d   = dir_q;
    first_d = first_q;
    up_d    = 1'b0;
    dn_d    = 1'b0;
    tmr_clr = 1'b0;
    tmr_run = 1'b0;
    if (!en_i) begin
      st_d    = ST_GAP;
      tmr_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_GAP: begin
          if (!at_mid)          tmr_clr = 1'b1;
          else if (us >= GAP_T) st_d    = ST_READY;
          else                  tmr_run = 1'b1;
        end
        ST_READY: begin
          if (!at_mid) begin
            st_d    = ST_PULSE;
            dir_d   = lvl;
            tmr_clr = 1'b1;
          end
        end
        ST_PULSE: begin
          if (lvl == dir_q) begin
            tmr_run = 1'b1;
          end else begin
            st_d    = ST_GAP;
            tmr_clr = 1'b1;
            if (at_mid && us >= ACC_T) begin
              if (first_q) begin
                first_d = 1'b0;
              end else begin
                up_d = (dir_q == LV_LO);
                dn_d = (dir_q == LV_HI);
              end
            end
          end
        end
        default: begin
          st_d    = ST_GAP;
          tmr_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_GAP;
      dir_q   <= LV_MID;
      first_q <= 1'b1;
      up_o    <= 1'b0;
      dn_o    <= 1'b0;
    end else begin
      st_q    <= st_d;
      dir_q   <= dir_d;
      first_q <= first_d;
      up_o    <= up_d;
      dn_o    <= dn_d;
    end
  end
endmodule

// File: rtl/tri_pulse_qual_chk.sv
module tri_pulse_qual_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic up_o,
  input logic dn_o,
  input logic first_q,
  input logic at_mid
);
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));
  p_up_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |=> !up_o);
  p_dn_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_o |=> !dn_o);
  p_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !up_o && !dn_o);
  p_discard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |=> !up_o && !dn_o);
  p_on_return_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o || dn_o) |-> $past(at_mid));
endmodule

bind tri_pulse_qual tri_pulse_qual_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .up_o   (up_o),
  .dn_o   (dn_o),
  .first_q(first_q),
  .at_mid (at_mid)
);

// File: tb/tri_pulse_qual_bench.sv
module tri_pulse_qual_bench;
  localparam int CPU = 2;
  localparam int ACC = 100;
  localparam int GAP = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1;
  logic lvl_hi_i = 1'b0;
  logic lvl_lo_i = 1'b0;
  logic up_o, dn_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  tri_pulse_qual #(.CYC_PER_US(CPU), .ACCEPT_US(ACC), .GAP_US(GAP)) u_tri_pulse_qual (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i),
    .lvl_hi_i(lvl_hi_i), .lvl_lo_i(lvl_lo_i),
    .up_o(up_o), .dn_o(dn_o)
  );

  always #5 clk = ~clk;

  // behavioural reference: 0 mid, 1 high, 2 low
  int m_s1, m_s2, m_gap, m_exc, m_dir;
  bit m_armed, m_in_exc, m_first;
  bit exp_up, exp_dn;

  function automatic int lvl_of(bit h, bit l);
    if (h && !l) return 1;
    if (l && !h) return 2;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_gap = 0; m_exc = 0; m_dir = 0;
      m_armed = 0; m_in_exc = 0; m_first = 1;
      exp_up = 0; exp_dn = 0;
    end else begin
      int lv;
      lv = m_s2;
      exp_up = 0; exp_dn = 0;
      if (!en_i) begin
        m_armed = 0; m_in_exc = 0; m_gap = 0;
      end else if (m_in_exc) begin
        if (lv == m_dir) m_exc++;
        else begin
          if (lv == 0 && m_exc >= ACC * CPU) begin
            if (m_first) m_first = 0;
            else begin
              exp_up = (m_dir == 2);
              exp_dn = (m_dir == 1);
            end
          end
          m_in_exc = 0; m_gap = 0;
        end
      end else if (m_armed) begin
        if (lv != 0) begin
          m_in_exc = 1; m_dir = lv; m_exc = 0; m_armed = 0;
        end
      end else begin
        if (lv != 0) m_gap = 0;
        else if (m_gap >= GAP * CPU) m_armed = 1;
        else m_gap++;
      end
      m_s2 = m_s1;
      m_s1 = lvl_of(lvl_hi_i, lvl_lo_i);
    end
  end

  int cnt_up = 0, cnt_dn = 0;

  always @(negedge clk) begin
    if (!finished) begin
      n_chk++;
      if (up_o !== exp_up || dn_o !== exp_dn) begin
        n_fail++;
        $display("FAIL R2 R3 R9 cycle compare t=%0t up/dn=%b%b expected %b%b",
                 $time, up_o, dn_o, exp_up, exp_dn);
      end
      if (up_o === 1'b1) cnt_up++;
      if (dn_o === 1'b1) cnt_dn++;
    end
  end

  task automatic drive(input bit h, input bit l, input int n);
    @(negedge clk);
    lvl_hi_i = h; lvl_lo_i = l;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic check_cnt(input string tag, input int eu, input int ed);
    n_chk++;
    if (cnt_up != eu || cnt_dn != ed) begin
      n_fail++;
      $display("FAIL %s strobes up=%0d dn=%0d expected up=%0d dn=%0d",
               tag, cnt_up, cnt_dn, eu, ed);
    end
    cnt_up = 0; cnt_dn = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (up_o !== 1'b0 || dn_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs %b%b expected 00", up_o, dn_o);
    end
    rst_ni = 1'b1;
    drive(0, 0, 40);
    // R5: first qualifying pulse swallowed
    drive(0, 1, 250); drive(0, 0, 40);
    check_cnt("R5 first pulse", 0, 0);
    // R2
    drive(0, 1, 250); drive(0, 0, 40);
    check_cnt("R2 low excursion", 1, 0);
    // R3
    drive(1, 0, 250); drive(0, 0, 40);
    check_cnt("R3 high excursion", 0, 1);
    // R4 glitch, boundary below and at acceptance, reversal
    drive(0, 1, 30); drive(0, 0, 40);
    check_cnt("R4 glitch", 0, 0);
    drive(0, 1, 200); drive(0, 0, 40);
    check_cnt("R4 200 cycles", 0, 0);
    drive(0, 1, 201); drive(0, 0, 40);
    check_cnt("R4 201 cycles", 1, 0);
    drive(1, 0, 100); drive(0, 1, 250); drive(0, 0, 40);
    check_cnt("R4 reversal", 0, 0);
    // R6 spacing
    drive(0, 1, 250); drive(0, 0, 5); drive(0, 1, 250); drive(0, 0, 40);
    check_cnt("R6 short gap", 1, 0);
    drive(1, 0, 250); drive(0, 0, 25); drive(1, 0, 250); drive(0, 0, 40);
    check_cnt("R6 long gap", 0, 2);
    // R7 enable
    drive(0, 1, 150);
    @(negedge clk); en_i = 1'b0;
    drive(0, 1, 20);
    @(negedge clk); en_i = 1'b1;
    drive(0, 1, 250); drive(0, 0, 40);
    check_cnt("R7 cancel", 0, 0);
    @(negedge clk); en_i = 1'b0;
    drive(0, 1, 250); drive(0, 0, 40); drive(1, 0, 250); drive(0, 0, 40);
    check_cnt("R7 disabled", 0, 0);
    @(negedge clk); en_i = 1'b1;
    drive(0, 0, 10); drive(0, 1, 250); drive(0, 0, 40);
    check_cnt("R7 reenabled short gap", 0, 0);
    // R8 both flags
    drive(1, 1, 250); drive(0, 0, 40);
    check_cnt("R8 both flags", 0, 0);
    drive(0, 1, 250); drive(1, 1, 40);
    check_cnt("R8 both as return", 1, 0);
    drive(0, 0, 40);
    // R9 long hold: nothing until return
    drive(0, 1, 1000);
    check_cnt("R9 during hold", 0, 0);
    drive(0, 0, 40);
    check_cnt("R9 after hold", 1, 0);
    finish_run();
  end
endmodule